// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer with memory-mapped registers. A 32-bit up-counter advances on a slow functional tick enable, optionally divided by a power-of-two prescaler. While the watchdog is armed, a wrap of the counter past all-ones raises a single-cycle reset request and reloads the counter from a load register. Software keeps the system alive by writing a different value to a trigger register, which reloads the counter.

Arming and disarming are guarded. A stop/start key register accepts only ordered two-word pairs. Writes to the control, load, trigger and key registers belong to the slow domain. Each of these writes is posted, and a per-register pending flag stays up for a fixed number of functional ticks until the write takes effect. While a flag is up, further writes to that register are dropped. The bus side is a single-cycle register interface with combinational read data. All logic runs on one clock, and `tick_en` marks the functional ticks.

Register byte offsets: revision 0x00, system config 0x04, control 0x08, count 0x0C, load 0x10, trigger 0x14, pending status 0x18, key 0x1C.

Top module: `wdk_top`

## Requirements
- R1: After reset the watchdog is armed, count and load both read 0xFFFFFFF0, trigger reads 0, control reads 0, pending status reads 0 and `rst_req` is low.
- R2: While armed with the prescaler off (control bit 5 = 0), every `tick_en` cycle adds one to the count.
- R3: On the tick that would advance the count past 0xFFFFFFFF while armed, the count reloads from the load register and `rst_req` is high for exactly one cycle.
- R4: With control bit 5 = 1 and control bits 4:2 = P, the count advances once per 2^P ticks. A trigger reload restarts the division phase.
- R5: Pending status bit 0 (control), bit 2 (load), bit 3 (trigger) and bit 4 (key) sets on an accepted write. It clears on the 4th following tick, and the written value takes effect in that same cycle. A write to a register whose bit is set is discarded.
- R6: A committed trigger write whose value differs from the current trigger contents reloads the count from the load register. An equal value leaves the count running.
- R7: Key word 0x0000AAAA followed directly by 0x00005555 disarms the watchdog. While disarmed the count holds and `rst_req` stays low.
- R8: Key word 0x0000BBBB followed directly by 0x00004444 arms the watchdog. Any other word after a first key word cancels the pair.
- R9: The revision register returns the REV_CODE parameter in bits 7:0. System config bit 0 is a plain read/write bit with immediate effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Functional tick enable, one cycle per slow tick |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (valid with bus_sel) |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle reset request on armed overflow |

## Verification
The prescaler is swept over every divide value, plus the bypass setting. Each case reads the count one tick before and exactly at its third increment, which separates an off-by-one divider from a correct one and a bypass that ignores bit 5 from a working bypass.

Key sequences are tried in three forms: the correct disarm pair, a correct first word followed by a foreign word and then the second word, and the correct arm pair. A held versus a moving count tells these cases apart.

Trigger writes of an equal value and of a different value show that reload depends on a change and not on the write itself. A write issued while the load register is still pending shows whether a busy register drops new writes.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_REV    = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_SYSCFG = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_LOAD   = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_TRIG   = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 5'h18;
    localparam logic [ADDR_W-1:0] OFF_KEY    = 5'h1C;

    localparam logic [DATA_W-1:0] KEY_OFF_A = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_OFF_B = 32'h0000_5555;
    localparam logic [DATA_W-1:0] KEY_ON_A  = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_ON_B  = 32'h0000_4444;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_003C;

    localparam int N_POSTED = 4;
    localparam int P_CTRL = 0;
    localparam int P_LOAD = 1;
    localparam int P_TRIG = 2;
    localparam int P_KEY  = 3;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_GOT_OFF,
        KEY_GOT_ON
    } key_st_e;

    function automatic logic [ADDR_W-1:0] posted_off(input int idx);
        case (idx)
            P_CTRL:  return OFF_CTRL;
            P_LOAD:  return OFF_LOAD;
            P_TRIG:  return OFF_TRIG;
            default: return OFF_KEY;
        endcase
    endfunction

    // status bit positions are software-visible and fixed
    function automatic int pend_bit(input int idx);
        case (idx)
            P_CTRL:  return 0;
            P_LOAD:  return 2;
            P_TRIG:  return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/wdk_posted.sv
module wdk_posted #(
    parameter int DW         = 32,
    parameter int SYNC_TICKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] din,
    input  logic          tick,
    output logic          busy,
    output logic          commit,
    output logic [DW-1:0] dout
);
    localparam int CW = $clog2(SYNC_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
    } st_t;

    st_t st_q, st_d;

    assign commit = st_q.busy && tick && (st_q.cnt == LAST);
    assign busy   = st_q.busy;
    assign dout   = st_q.data;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (wr) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.data = din;
            end
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy);
    assert_pend_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> $stable(dout));
endmodule

// File: rtl/wdk_prescale.sv
module wdk_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             en,
    input  logic [PTV_W-1:0] ptv,
    output logic             fire
);
    localparam int PRE_W = (1 << PTV_W) - 1;
    localparam int MW    = PRE_W + 1;

    logic [PRE_W-1:0] pre_q, pre_d;
    logic [MW-1:0]    mask;

    always_comb begin
        mask  = ({{PRE_W{1'b0}}, 1'b1} << ptv) - 1'b1;
        fire  = run && (!en || (pre_q >= mask[PRE_W-1:0]));
        pre_d = pre_q;
        if (clr || !en)  pre_d = '0;
        else if (fire)   pre_d = '0;
        else if (run)    pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assert_div_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pre_q == '0));
    assert_div_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr && en) |=> $stable(pre_q));
endmodule

// File: rtl/wdk_keycheck.sv
module wdk_keycheck
    import wdk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] word,
    output logic              armed
);
    typedef struct packed {
        key_st_e st;
        logic    armed;
    } ks_t;

    ks_t ks_q, ks_d;

    assign armed = ks_q.armed;

    always_comb begin
        ks_d = ks_q;
        if (commit) begin
            if (ks_q.st == KEY_GOT_OFF && word == KEY_OFF_B) begin
                ks_d.armed = 1'b0;
                ks_d.st    = KEY_IDLE;
            end else if (ks_q.st == KEY_GOT_ON && word == KEY_ON_B) begin
                ks_d.armed = 1'b1;
                ks_d.st    = KEY_IDLE;
            end else if (word == KEY_OFF_A) begin
                ks_d.st = KEY_GOT_OFF;
            end else if (word == KEY_ON_A) begin
                ks_d.st = KEY_GOT_ON;
            end else begin
                ks_d.st = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ks_q <= '{st: KEY_IDLE, armed: 1'b1};
        else        ks_q <= ks_d;
    end

    assert_arm_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(commit) && $past(word) == KEY_ON_B));
    assert_disarm_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed) |-> ($past(commit) && $past(word) == KEY_OFF_B));
endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int                SYNC_TICKS = 4,
    parameter int                PTV_W      = 3,
    parameter logic [DATA_W-1:0] LOAD_INIT  = 32'hFFFF_FFF0,
    parameter logic [7:0]        REV_CODE   = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    localparam int PTV_LO = 2;
    localparam int PEN_B  = PTV_LO + PTV_W;

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] trig;
        logic [DATA_W-1:0] ctrl;
        logic              syscfg;
        logic              rst_req;
    } top_t;

    top_t cur_q, nxt_d;

    logic [N_POSTED-1:0] p_busy, p_commit;
    logic [DATA_W-1:0]   p_data [N_POSTED];
    logic [DATA_W-1:0]   pend;
    logic                armed, step, reload;

    for (genvar gi = 0; gi < N_POSTED; gi++) begin : g_post
        wdk_posted #(.DW(DATA_W), .SYNC_TICKS(SYNC_TICKS)) u_post (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (bus_sel && bus_we && bus_addr == posted_off(gi)),
            .din    (bus_wdata),
            .tick   (tick_en),
            .busy   (p_busy[gi]),
            .commit (p_commit[gi]),
            .dout   (p_data[gi])
        );
    end

    wdk_keycheck u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (p_commit[P_KEY]),
        .word   (p_data[P_KEY]),
        .armed  (armed)
    );

    assign reload = p_commit[P_TRIG] && (p_data[P_TRIG] != cur_q.trig);

    wdk_prescale #(.PTV_W(PTV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tick_en && armed),
        .clr   (reload),
        .en    (cur_q.ctrl[PEN_B]),
        .ptv   (cur_q.ctrl[PEN_B-1:PTV_LO]),
        .fire  (step)
    );

    always_comb begin
        pend = '0;
        for (int i = 0; i < N_POSTED; i++) pend[pend_bit(i)] = p_busy[i];
    end

    always_comb begin
        nxt_d = cur_q;
        nxt_d.rst_req = 1'b0;
        if (bus_sel && bus_we && bus_addr == OFF_SYSCFG) nxt_d.syscfg = bus_wdata[0];
        if (p_commit[P_CTRL]) nxt_d.ctrl = p_data[P_CTRL];
        if (p_commit[P_LOAD]) nxt_d.load = p_data[P_LOAD];
        if (p_commit[P_TRIG]) nxt_d.trig = p_data[P_TRIG];
        if (reload) begin
            nxt_d.cnt = cur_q.load;
        end else if (step) begin
            if (&cur_q.cnt) begin
                nxt_d.cnt     = cur_q.load;
                nxt_d.rst_req = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{cnt: LOAD_INIT, load: LOAD_INIT, trig: '0, ctrl: '0,
                       syscfg: 1'b0, rst_req: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_REV:    bus_rdata = {{(DATA_W-8){1'b0}}, REV_CODE};
            OFF_SYSCFG: bus_rdata = {{(DATA_W-1){1'b0}}, cur_q.syscfg};
            OFF_CTRL:   bus_rdata = cur_q.ctrl & CTRL_MASK;
            OFF_COUNT:  bus_rdata = cur_q.cnt;
            OFF_LOAD:   bus_rdata = cur_q.load;
            OFF_TRIG:   bus_rdata = cur_q.trig;
            OFF_PEND:   bus_rdata = pend;
            OFF_KEY:    bus_rdata = p_data[P_KEY];
            default:    bus_rdata = '0;
        endcase
    end

    assign rst_req = cur_q.rst_req;

    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    assert_req_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cur_q.cnt == $past(cur_q.load)));
    assert_hold_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !reload) |=> $stable(cur_q.cnt));
    assert_no_req_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !rst_req);
    assert_trig_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cur_q.cnt == $past(cur_q.load)));
endmodule

// File: tb/wdk_top_test.sv
module wdk_top_test;
    import wdk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] trig_val = '0;

    always #2.5 clk = ~clk;

    wdk_top uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 count", OFF_COUNT, 32'hFFFF_FFF0);
        rdchk("R1 load",  OFF_LOAD,  32'hFFFF_FFF0);
        rdchk("R1 trig",  OFF_TRIG,  32'h0);
        rdchk("R1 ctrl",  OFF_CTRL,  32'h0);
        rdchk("R1 pend",  OFF_PEND,  32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R9 revision and system config
        rdchk("R9 rev", OFF_REV, 32'h21);
        wr(OFF_SYSCFG, 32'h1);
        rdchk("R9 syscfg set", OFF_SYSCFG, 32'h1);
        wr(OFF_SYSCFG, 32'h0);
        rdchk("R9 syscfg clr", OFF_SYSCFG, 32'h0);

        // R2 counting, R3 overflow
        ticks(15);
        rdchk("R2 count after 15", OFF_COUNT, 32'hFFFF_FFFF);
        check("R3 no early req", {31'b0, rst_req}, 32'h0);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        check("R3 req high", {31'b0, rst_req}, 32'h1);
        @(negedge clk);
        check("R3 req one cycle", {31'b0, rst_req}, 32'h0);
        rdchk("R3 reload", OFF_COUNT, 32'hFFFF_FFF0);

        // R5 pending and drop-while-busy
        wr(OFF_LOAD, 32'h100);
        rdchk("R5 load pend bit2", OFF_PEND, 32'h4);
        rdchk("R5 load not yet", OFF_LOAD, 32'hFFFF_FFF0);
        wr(OFF_LOAD, 32'h200);
        ticks(3);
        rdchk("R5 still pend", OFF_PEND, 32'h4);
        ticks(1);
        rdchk("R5 pend clear", OFF_PEND, 32'h0);
        rdchk("R5 busy write dropped", OFF_LOAD, 32'h100);
        rdchk("R2 count 4 ticks", OFF_COUNT, 32'hFFFF_FFF4);

        // R6 trigger: equal value no reload, changed value reloads
        wr(OFF_TRIG, 32'h0);
        rdchk("R5 trig pend bit3", OFF_PEND, 32'h8);
        ticks(4);
        rdchk("R6 equal no reload", OFF_COUNT, 32'hFFFF_FFF8);
        trig_val = 32'h1234;
        wr(OFF_TRIG, trig_val);
        ticks(4);
        rdchk("R6 changed reloads", OFF_COUNT, 32'h100);

        // R7 disarm
        wr(OFF_KEY, KEY_OFF_A);
        rdchk("R5 key pend bit4", OFF_PEND, 32'h10);
        ticks(4);
        wr(OFF_KEY, KEY_OFF_B);
        ticks(4);
        rdchk("R7 count at disarm", OFF_COUNT, 32'h108);
        ticks(10);
        rdchk("R7 count held", OFF_COUNT, 32'h108);

        // R8 broken pair does not arm
        wr(OFF_KEY, KEY_ON_A);   ticks(4);
        wr(OFF_KEY, 32'h1234);   ticks(4);
        wr(OFF_KEY, KEY_ON_B);   ticks(4);
        rdchk("R8 broken pair stays off", OFF_COUNT, 32'h108);

        // R8 correct pair arms
        wr(OFF_KEY, KEY_ON_A);   ticks(4);
        wr(OFF_KEY, KEY_ON_B);   ticks(4);
        rdchk("R8 held through arm", OFF_COUNT, 32'h108);
        ticks(5);
        rdchk("R8 counting again", OFF_COUNT, 32'h10D);

        // R4 prescaler sweep over all divide values, then bypass
        for (int p = 0; p <= 8; p++) begin
            logic [31:0] cv;
            int per;
            cv  = (p < 8) ? (32'h20 | (32'(p) << 2)) : 32'h1C;
            per = (p < 8) ? (1 << p) : 1;
            wr(OFF_CTRL, cv);
            ticks(4);
            rdchk("R4 ctrl readback", OFF_CTRL, cv);
            trig_val = ~trig_val;
            wr(OFF_TRIG, trig_val);
            ticks(4);
            rdchk("R6 reload for sweep", OFF_COUNT, 32'h100);
            ticks(3 * per - 1);
            rdchk("R4 one tick short", OFF_COUNT, 32'h102);
            ticks(1);
            rdchk("R4 third step", OFF_COUNT, 32'h103);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule